// File: doc/BRIEF.md
# Queue-Driven Interrupt Status Logic

This block keeps the interrupt state of a packet buffer controller. An eight-bit status register collects two kinds of causes. Two bits follow queue occupancy: one is forced high while the transmit queue is empty, the other while the transmit-completion queue holds entries. The other bits are latched from single-cycle event pulses (packet received, buffer allocated, receive overrun) and stay set until something clears them. An eight-bit mask register selects which status bits may drive the single active-high interrupt line.

The host clears status bits by writing an acknowledge value. Only a fixed subset of bit positions can be cleared this way. Writing the transmit-complete bit in an acknowledge also sends a one-cycle pop request to the transmit-completion queue. The queues themselves and the register decode sit outside this block. The block reports the receive queue's state after each pop, so the receive bit shows whether more packets are waiting.

Top module: `irq_status_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `status` reads 0x04, `mask` reads 0x00, and `irq` and `txdone_pop` are low.
- R2: A cycle after `txq_empty` is sampled high, `status` bit 2 (value 0x04) is 1. An acknowledge in that same cycle does not clear it.
- R3: A cycle after `donq_nonempty` is sampled high, `status` bit 1 (value 0x02) is 1. An acknowledge in that same cycle does not clear it.
- R4: A pulse on `rx_evt` sets bit 0 (0x01), a pulse on `alloc_evt` sets bit 3 (0x08) and a pulse on `ovrn_evt` sets bit 4 (0x10), each from the next cycle on. Each bit stays set until it is cleared.
- R5: An acknowledge (`ack_we` high) clears exactly the status bits set in `ack_data & 0xD6`. Bits 0, 3 and 5 are never changed by an acknowledge.
- R6: After `rx_pop`, bit 0 equals `rx_more`, which says whether the receive queue is still non-empty. If `rx_evt` is high in the same cycle, bit 0 is set.
- R7: `alloc_clr` clears bit 3. If `alloc_evt` is high in the same cycle, bit 3 is set.
- R8: `mask_we` loads `mask_data` into `mask` on the next cycle. In every cycle, `irq` equals the OR of `status & mask`.
- R9: `txdone_pop` is high for exactly the one cycle that follows an acknowledge with `ack_data` bit 1 set, and is low at all other times.
- R10: Within a cycle, the acknowledge clear is applied first, then the receive-pop update, then event sets, and then the two forced queue bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txq_empty | input | 1 | Transmit queue length is zero |
| donq_nonempty | input | 1 | Transmit-completion queue holds entries |
| rx_evt | input | 1 | Packet received pulse |
| alloc_evt | input | 1 | Allocation succeeded pulse |
| alloc_clr | input | 1 | New allocation request, clears the allocation bit |
| ovrn_evt | input | 1 | Receive overrun pulse |
| rx_pop | input | 1 | Receive queue head removed |
| rx_more | input | 1 | Receive queue non-empty after that removal |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_data | input | 8 | Acknowledge value |
| mask_we | input | 1 | Mask write strobe |
| mask_data | input | 8 | New mask value |
| status | output | 8 | Interrupt status register |
| mask | output | 8 | Interrupt mask register |
| irq | output | 1 | Interrupt line, registered |
| txdone_pop | output | 1 | One-cycle pop request to the completion queue |

## Verification
Directed sequences separate the two kinds of bit. Level bits are acknowledged while their queue condition is held and again after it is released: they must survive the first acknowledge and clear on the second. Latched bits are acknowledged with all ones, which shows which positions an acknowledge can reach. Collision cases put an event and its clearing action in the same cycle to fix the ordering. Random traffic with a fixed seed then drives every input together, with random masks, and is compared each cycle against a bench model. This catches ordering and masking errors that only appear when inputs coincide.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int unsigned ST_W      = 8;
  localparam int unsigned RCV_BIT   = 0;
  localparam int unsigned TXC_BIT   = 1;
  localparam int unsigned TXE_BIT   = 2;
  localparam int unsigned ALLOC_BIT = 3;
  localparam int unsigned OVRN_BIT  = 4;
  localparam logic [ST_W-1:0] ACK_CLEARABLE = 8'hD6;
  localparam logic [ST_W-1:0] STATUS_RST    = 8'h04;
endpackage

// File: rtl/irq_status_core.sv
module irq_status_core
  import isr_pkg::*;
#(
  parameter int unsigned W        = ST_W,
  parameter logic [W-1:0] ACK_MSK = ACK_CLEARABLE,
  parameter logic [W-1:0] RST_VAL = STATUS_RST
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         txq_empty,
  input  logic         donq_nonempty,
  input  logic         rx_evt,
  input  logic         alloc_evt,
  input  logic         alloc_clr,
  input  logic         ovrn_evt,
  input  logic         rx_pop,
  input  logic         rx_more,
  input  logic         ack_we,
  input  logic [W-1:0] ack_data,
  output logic [W-1:0] status_q,
  output logic [W-1:0] status_d
);
  logic [W-1:0] after_ack;
  logic [W-1:0] after_evt;

  // Ordering: acknowledge, receive pop, events, then forced queue levels.
  always_comb begin
    after_ack = status_q;
    if (ack_we) after_ack = status_q & ~(ack_data & ACK_MSK);
    after_evt = after_ack;
    if (rx_pop)    after_evt[RCV_BIT]   = rx_more;
    if (rx_evt)    after_evt[RCV_BIT]   = 1'b1;
    if (alloc_clr) after_evt[ALLOC_BIT] = 1'b0;
    if (alloc_evt) after_evt[ALLOC_BIT] = 1'b1;
    if (ovrn_evt)  after_evt[OVRN_BIT]  = 1'b1;
    status_d = after_evt;
    if (txq_empty)     status_d[TXE_BIT] = 1'b1;
    if (donq_nonempty) status_d[TXC_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= RST_VAL;
    else     status_q <= status_d;
  end

  assert_txe_forced_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(txq_empty) && !$past(rst)) |-> status_q[TXE_BIT]);
  assert_txc_forced_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(donq_nonempty) && !$past(rst)) |-> status_q[TXC_BIT]);
  assert_ovrn_set_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(ovrn_evt) && !$past(rst)) |-> status_q[OVRN_BIT]);
  assert_ack_skips_rcv_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(status_q[RCV_BIT]) && !$past(rx_pop) && !$past(rst)) |-> status_q[RCV_BIT]);
  assert_ack_clears_ovrn_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(ack_we && ack_data[OVRN_BIT] && !ovrn_evt) && !$past(rst)) |-> !status_q[OVRN_BIT]);
  assert_pop_empties_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(rx_pop && !rx_more && !rx_evt) && !$past(rst)) |-> !status_q[RCV_BIT]);
  assert_alloc_clr_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(alloc_clr && !alloc_evt) && !$past(rst)) |-> !status_q[ALLOC_BIT]);
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_we,
  input  logic [W-1:0] mask_data,
  input  logic [W-1:0] status_d,
  output logic [W-1:0] mask_q,
  output logic         irq_q
);
  logic [W-1:0] mask_d;

  always_comb mask_d = mask_we ? mask_data : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq_q  <= |(status_d & mask_d);
    end
  end

  assert_mask_load_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_we) && !$past(rst)) |-> (mask_q == $past(mask_data)));
endmodule

// File: rtl/irq_ack_pop.sv
module irq_ack_pop
  import isr_pkg::*;
#(
  parameter int unsigned W = ST_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ack_we,
  input  logic [W-1:0] ack_data,
  output logic         pop_q
);
  always_ff @(posedge clk) begin
    if (rst) pop_q <= 1'b0;
    else     pop_q <= ack_we & ack_data[TXC_BIT];
  end

  assert_pop_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ack_we && ack_data[TXC_BIT])) |-> !pop_q);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import isr_pkg::*;
#(
  parameter int unsigned W = ST_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         txq_empty,
  input  logic         donq_nonempty,
  input  logic         rx_evt,
  input  logic         alloc_evt,
  input  logic         alloc_clr,
  input  logic         ovrn_evt,
  input  logic         rx_pop,
  input  logic         rx_more,
  input  logic         ack_we,
  input  logic [W-1:0] ack_data,
  input  logic         mask_we,
  input  logic [W-1:0] mask_data,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         irq,
  output logic         txdone_pop
);
  logic [W-1:0] status_next;

  irq_status_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .txq_empty(txq_empty), .donq_nonempty(donq_nonempty),
    .rx_evt(rx_evt), .alloc_evt(alloc_evt), .alloc_clr(alloc_clr),
    .ovrn_evt(ovrn_evt), .rx_pop(rx_pop), .rx_more(rx_more),
    .ack_we(ack_we), .ack_data(ack_data),
    .status_q(status), .status_d(status_next)
  );

  irq_mask_gate #(.W(W)) u_gate (
    .clk(clk), .rst(rst), .mask_we(mask_we), .mask_data(mask_data),
    .status_d(status_next), .mask_q(mask), .irq_q(irq)
  );

  irq_ack_pop #(.W(W)) u_pop (
    .clk(clk), .rst(rst), .ack_we(ack_we), .ack_data(ack_data), .pop_q(txdone_pop)
  );

  assert_irq_match_R8: assert property (@(posedge clk) disable iff (rst)
    irq == (|(status & mask)));
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (status == STATUS_RST && mask == '0 && !irq && !txdone_pop));
endmodule

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txq_empty = 0, donq_nonempty = 0, rx_evt = 0, alloc_evt = 0, alloc_clr = 0;
  logic ovrn_evt = 0, rx_pop = 0, rx_more = 0, ack_we = 0, mask_we = 0;
  logic [7:0] ack_data = 0, mask_data = 0;
  logic [7:0] status, mask;
  logic irq, txdone_pop;

  int checks = 0, failures = 0;
  logic [7:0] e_status = 8'h04, e_mask = 8'h00;
  logic e_pop = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_status_unit u_irq_status_unit (
    .clk(clk), .rst(rst), .txq_empty(txq_empty), .donq_nonempty(donq_nonempty),
    .rx_evt(rx_evt), .alloc_evt(alloc_evt), .alloc_clr(alloc_clr), .ovrn_evt(ovrn_evt),
    .rx_pop(rx_pop), .rx_more(rx_more), .ack_we(ack_we), .ack_data(ack_data),
    .mask_we(mask_we), .mask_data(mask_data), .status(status), .mask(mask),
    .irq(irq), .txdone_pop(txdone_pop)
  );

  function automatic logic [7:0] model_next(logic [7:0] s);
    logic [7:0] n = s;
    if (ack_we) n = n & ~(ack_data & 8'hD6);
    if (rx_pop) n[0] = rx_more;
    if (rx_evt) n[0] = 1'b1;
    if (alloc_clr) n[3] = 1'b0;
    if (alloc_evt) n[3] = 1'b1;
    if (ovrn_evt) n[4] = 1'b1;
    if (txq_empty) n[2] = 1'b1;
    if (donq_nonempty) n[1] = 1'b1;
    return n;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    rx_evt = 0; alloc_evt = 0; alloc_clr = 0; ovrn_evt = 0; rx_pop = 0;
    rx_more = 0; ack_we = 0; mask_we = 0; ack_data = 0; mask_data = 0;
  endtask

  // Inputs are set at negedge; one edge advances model and design; compare at next negedge.
  task automatic step(string tag);
    @(posedge clk);
    e_status = model_next(e_status);
    if (mask_we) e_mask = mask_data;
    e_pop = ack_we & ack_data[1];
    @(negedge clk);
    chk({tag, " status"}, 32'(status), 32'(e_status));
    chk({tag, " mask R8"}, 32'(mask), 32'(e_mask));
    chk({tag, " irq R8"}, 32'(irq), 32'(|(e_status & e_mask)));
    chk({tag, " pop R9"}, 32'(txdone_pop), 32'(e_pop));
    clear_in();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 status in reset", 32'(status), 32'h04);
    chk("R1 mask in reset", 32'(mask), 32'h00);
    chk("R1 irq in reset", 32'(irq), 32'h0);
    chk("R1 pop in reset", 32'(txdone_pop), 32'h0);
    rst = 0;
    step("R1 first cycle");

    mask_we = 1; mask_data = 8'hFF; step("R8 mask all");
    ack_we = 1; ack_data = 8'h04; step("R2 ack tx-empty while queue idle");
    txq_empty = 1; step("R2 forced");
    ack_we = 1; ack_data = 8'h04; step("R2 ack held by level");
    chk("R2 bit2 survives ack", 32'(status[2]), 32'h1);
    txq_empty = 0; ack_we = 1; ack_data = 8'h04; step("R2 ack after release");
    chk("R2 bit2 cleared", 32'(status[2]), 32'h0);

    donq_nonempty = 1; step("R3 forced");
    ack_we = 1; ack_data = 8'h02; step("R3 ack held and pop R9");
    chk("R3 bit1 survives ack", 32'(status[1]), 32'h1);
    chk("R9 pop pulse", 32'(txdone_pop), 32'h1);
    donq_nonempty = 0; step("R9 pop drops");
    chk("R9 pop single cycle", 32'(txdone_pop), 32'h0);
    ack_we = 1; ack_data = 8'h02; step("R3 clear after release");

    rx_evt = 1; alloc_evt = 1; ovrn_evt = 1; step("R4 events");
    chk("R4 latched bits", 32'(status & 8'h19), 32'h19);
    ack_we = 1; ack_data = 8'hFF; step("R5 ack all ones");
    chk("R5 only clearable bits gone", 32'(status & 8'h19), 32'h09);
    rx_pop = 1; rx_more = 1; step("R6 pop leaves more");
    chk("R6 rcv stays", 32'(status[0]), 32'h1);
    rx_pop = 1; rx_more = 0; rx_evt = 1; step("R6 pop empty with event");
    chk("R6 event wins", 32'(status[0]), 32'h1);
    rx_pop = 1; rx_more = 0; step("R6 pop empties");
    chk("R6 rcv cleared", 32'(status[0]), 32'h0);
    alloc_clr = 1; alloc_evt = 1; step("R7 set wins");
    chk("R7 alloc kept", 32'(status[3]), 32'h1);
    alloc_clr = 1; step("R7 clear");
    chk("R7 alloc cleared", 32'(status[3]), 32'h0);
    mask_we = 1; mask_data = 8'h10; ovrn_evt = 1; step("R8 masked irq");
    chk("R8 irq on overrun", 32'(irq), 32'h1);
    ack_we = 1; ack_data = 8'h10; ovrn_evt = 1; step("R10 event after ack");
    chk("R10 overrun set wins", 32'(status[4]), 32'h1);

    for (int i = 0; i < 3000; i++) begin
      txq_empty = ($urandom % 4) == 0;
      donq_nonempty = ($urandom % 4) == 0;
      rx_evt = ($urandom % 6) == 0;
      alloc_evt = ($urandom % 6) == 0;
      alloc_clr = ($urandom % 6) == 0;
      ovrn_evt = ($urandom % 8) == 0;
      rx_pop = ($urandom % 5) == 0;
      rx_more = $urandom % 2;
      ack_we = ($urandom % 3) == 0;
      ack_data = 8'($urandom);
      mask_we = ($urandom % 10) == 0;
      mask_data = 8'($urandom);
      step("random R2 R3 R4 R5 R6 R7 R10");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule